// File: doc/BRIEF.md
# Bidirectional GPIO Port with Separate Output Latch

This block is one 8-bit general-purpose I/O port of a microcontroller. Software sees three registers on a small register bus: a pin-level register, an output-latch register and a direction register. Writing either the pin-level or the latch register stores into the output latch. Reading the pin-level register returns the synchronized pin levels. Reading the latch register returns the stored drive value. Because the two reads are separate, read-modify-write sequences that go through the latch register never copy external pin states into the latch.

The pad side carries an output value and an output enable per pin. The block also takes in per-pin qualifiers owned by other blocks: an analog-select vector, a comparator-enable vector and a peripheral-output override pair. It also takes a flag saying the oscillator has claimed the two top pins. These qualifiers mask reads to zero and gate the pad drive. The converter, comparators, oscillator and pad electrics live elsewhere.

Top module: `gpio_port_rmw`

## Requirements
- R1: Reset sets the direction register to 8'hFF (all pins are inputs, so `pin_oe` is 8'h00) and clears the output latch to 8'h00.
- R2: A write strobe with `bus_addr` 0 (pin-level register) or 1 (latch register) loads `bus_wdata` into the output latch at that clock edge. A write with `bus_addr` 2 loads the direction register.
- R3: A direction bit of 0 makes its pin an output: `pin_oe` is 1 and `pin_out` carries the latch bit. A direction bit of 1 sets `pin_oe` to 0.
- R4: Reading `bus_addr` 0 returns `pin_in` through a two-flop synchronizer. A level change becomes visible after the second rising edge and not after the first.
- R5: Through `bus_addr` 0, a pin whose `ana_sel` bit or `cmp_en` bit is 1 reads 0. Such a pin's direction bit still controls its `pin_oe`.
- R6: While `osc_claim` is 1, bits 7:6 read 0 at addresses 0, 1 and 2. Writes leave bits 7:6 of the latch and direction registers unchanged, and `pin_oe[7:6]` and `pin_out[7:6]` are 0.
- R7: A pin whose `alt_oe` bit is 1 is driven (`pin_oe` is 1) with the value of its `alt_out` bit, in place of the latch. The oscillator claim of R6 takes precedence on pins 7:6.
- R8: Reading `bus_addr` 1 returns the stored latch value, whatever levels are present on `pin_in`.
- R9: `bus_addr` 3 reads as 8'h00, and a write to it changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 2 | Register select: 0 pin levels, 1 latch, 2 direction, 3 unused |
| bus_we | input | 1 | Single-cycle write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Combinational read data of the addressed register |
| pin_in | input | 8 | Sampled pad input levels |
| pin_out | output | 8 | Pad output values |
| pin_oe | output | 8 | Pad output enables, 1 drives the pad |
| ana_sel | input | 8 | Per-pin analog mode, 1 masks the digital read |
| cmp_en | input | 8 | Per-pin comparator use, 1 masks the digital read |
| osc_claim | input | 1 | Oscillator owns pins 7:6 |
| alt_oe | input | 8 | Per-pin peripheral output enable |
| alt_out | input | 8 | Per-pin peripheral output value |

## Verification
The bench targets the interplay of the masks. It drives an analog pin set as an output, which a design that gated drive by analog mode would leave undriven. It drives comparator-only masking, which a design testing only `ana_sel` would leak. It runs an oscillator claim over stale latch bits, which a design would expose on read or on `pin_out` if it masked only writes. It also checks that the synchronizer latency is exactly two edges, and that the latch read stays at the stored value while the pins show other levels. A design that fed reads straight from the pins, or wrote stray data through address 3, would return visibly different read data.

// File: rtl/gpio_port_rmw.sv
module gpio_port_rmw #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [1:0]   bus_addr,
  input  logic         bus_we,
  input  logic [W-1:0] bus_wdata,
  output logic [W-1:0] bus_rdata,
  input  logic [W-1:0] pin_in,
  output logic [W-1:0] pin_out,
  output logic [W-1:0] pin_oe,
  input  logic [W-1:0] ana_sel,
  input  logic [W-1:0] cmp_en,
  input  logic         osc_claim,
  input  logic [W-1:0] alt_oe,
  input  logic [W-1:0] alt_out
);
  localparam logic [W-1:0] OSC_PINS = {2'b11, {(W-2){1'b0}}};

  logic [W-1:0] dir_q, lat_q, sync1_q, sync2_q, keep;

  assign keep = osc_claim ? ~OSC_PINS : '1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q   <= '1;
      lat_q   <= '0;
      sync1_q <= '0;
      sync2_q <= '0;
    end else begin
      sync1_q <= pin_in;
      sync2_q <= sync1_q;
      if (bus_we) begin
        case (bus_addr)
          2'd0, 2'd1: lat_q <= (lat_q & ~keep) | (bus_wdata & keep);
          2'd2:       dir_q <= (dir_q & ~keep) | (bus_wdata & keep);
          default:    ;
        endcase
      end
    end
  end

  always_comb begin
    case (bus_addr)
      2'd0:    bus_rdata = sync2_q & ~(ana_sel | cmp_en) & keep;
      2'd1:    bus_rdata = lat_q & keep;
      2'd2:    bus_rdata = dir_q & keep;
      default: bus_rdata = '0;
    endcase
  end

  assign pin_oe  = (~dir_q | alt_oe) & keep;
  assign pin_out = ((lat_q & ~alt_oe) | (alt_out & alt_oe)) & keep;

  p_reset_state_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (pin_oe == '0 && pin_out == '0));

  p_latch_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == 2'd1 && !osc_claim && alt_oe == '0) |=>
      (pin_out == $past(bus_wdata) || $changed(alt_oe) || $changed(osc_claim)));

  p_analog_mask_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == 2'd0) |-> ((bus_rdata & (ana_sel | cmp_en)) == '0));

  p_osc_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    osc_claim |-> (bus_rdata[W-1:W-2] == 2'b00 && pin_oe[W-1:W-2] == 2'b00
                   && pin_out[W-1:W-2] == 2'b00));

  p_alt_drive_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !osc_claim |-> (((alt_oe & ~pin_oe) == '0) && ((pin_out & alt_oe) == (alt_out & alt_oe))));

  p_unused_addr_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == 2'd3) |-> (bus_rdata == '0));
endmodule

// File: tb/sim_gpio_port_rmw.sv
module sim_gpio_port_rmw;
  logic       clk = 0, rst_n = 0;
  logic [1:0] bus_addr = 0;
  logic       bus_we = 0;
  logic [7:0] bus_wdata = 0, bus_rdata, pin_in = 0, pin_out, pin_oe;
  logic [7:0] ana_sel = 0, cmp_en = 0, alt_oe = 0, alt_out = 0;
  logic       osc_claim = 0;
  int checks = 0, failures = 0;
  bit done = 0;

  always #5ns clk = ~clk;

  gpio_port_rmw u0 (.clk, .rst_n, .bus_addr, .bus_we, .bus_wdata, .bus_rdata,
    .pin_in, .pin_out, .pin_oe, .ana_sel, .cmp_en, .osc_claim, .alt_oe, .alt_out);

  // {ana, cmp, osc, pin, lat, dir, aoe, aout, exp_port, exp_lat, exp_dir, exp_oe, exp_out}
  localparam logic [96:0] VEC [5] = '{
    {8'h00,8'h00,1'b0,8'hA5,8'h3C,8'hF0,8'h00,8'h00, 8'hA5,8'h3C,8'hF0,8'h0F,8'h3C},
    {8'h2F,8'h00,1'b0,8'hFF,8'hC3,8'h00,8'h00,8'h00, 8'hD0,8'hC3,8'h00,8'hFF,8'hC3},
    {8'h00,8'h0F,1'b1,8'hFF,8'hFF,8'h0F,8'h00,8'h00, 8'h30,8'h3F,8'h0F,8'h30,8'h3F},
    {8'h00,8'h00,1'b0,8'h00,8'h5A,8'hFF,8'h10,8'h00, 8'h00,8'h5A,8'hFF,8'h10,8'h4A},
    {8'h20,8'h00,1'b0,8'hFF,8'h00,8'hDF,8'h00,8'h00, 8'hDF,8'h00,8'hDF,8'h20,8'h00}
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_we = 1;
    @(negedge clk); bus_we = 0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); bus_addr = a; #1; d = bus_rdata;
  endtask

  initial begin
    logic [7:0] r;
    #22ns rst_n = 1;
    rd(2, r); check("R1 dir reset", r, 8'hFF);
    rd(1, r); check("R1 latch reset", r, 8'h00);
    check("R1 oe reset", pin_oe, 8'h00);

    for (int i = 0; i < 5; i++) begin
      logic [96:0] v;
      v = VEC[i];
      @(negedge clk);
      ana_sel = v[96:89]; cmp_en = v[88:81]; osc_claim = v[80]; pin_in = v[79:72];
      alt_oe = v[55:48]; alt_out = v[47:40];
      wr(1, v[71:64]);
      wr(2, v[63:56]);
      @(negedge clk);
      rd(0, r); check($sformatf("R4 R5 R6 port vec%0d", i), r, v[39:32]);
      rd(1, r); check($sformatf("R2 R6 R8 latch vec%0d", i), r, v[31:24]);
      rd(2, r); check($sformatf("R2 R6 dir vec%0d", i), r, v[23:16]);
      check($sformatf("R3 R5 R7 oe vec%0d", i), pin_oe, v[15:8]);
      check($sformatf("R3 R7 out vec%0d", i), pin_out, v[7:0]);
    end

    @(negedge clk);
    ana_sel = 0; cmp_en = 0; osc_claim = 0; alt_oe = 0; alt_out = 0; pin_in = 8'h0F;
    wr(0, 8'h96);
    rd(1, r); check("R2 port-address write to latch", r, 8'h96);
    rd(0, r); check("R8 pin read independent of latch", r, 8'h0F);
    pin_in = 8'hF0;
    @(posedge clk); #1; bus_addr = 0; #1;
    check("R4 one edge not yet visible", bus_rdata, 8'h0F);
    @(posedge clk); #1;
    check("R4 visible after two edges", bus_rdata, 8'hF0);
    rd(1, r); check("R8 latch unchanged by pins", r, 8'h96);

    wr(3, 8'h55);
    rd(3, r); check("R9 addr3 reads zero", r, 8'h00);
    rd(1, r); check("R9 latch untouched", r, 8'h96);
    rd(2, r); check("R9 dir untouched", r, 8'hDF);

    @(negedge clk); osc_claim = 1;
    wr(1, 8'h00);
    @(negedge clk); osc_claim = 0; #1;
    check("R6 claimed latch bits kept", pin_out & 8'hC0, 8'h80);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #200us;
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule